// File: doc/BRIEF.md
# Thresholded Frame Sync Correlator

This block watches a serial bit stream, one bit per clock, for a 64-bit synchronisation word. The most recent 64 bits form a sliding window. Every window is compared bit by bit with an active reference word. The number of agreeing positions, called the score, is found by a four-stage adder pipeline. The score is then tested against a limit chosen by a 2-bit error-tolerance code. For every window evaluated, the block raises either a one-cycle detect pulse or a one-cycle loss pulse.

The reference is loaded in two steps. A staging register takes a new word on a load strobe. A transparent holding stage then decides which word is active: it passes the staging register through while its open input is high, and it freezes the active word while that input is low. Software-free control logic can therefore stage the next pattern while the current one is still being matched. The block also forwards the stream, with a fixed delay, so that downstream framing logic can line the data up with the detect pulses.

Top module: `sync_corr`

## Requirements
- R1: While rst_ni is low, detect_o, loss_o and data_o are all low.
- R2: After reset is released, neither pulse is raised until 64 bits have been shifted in. The first possible pulse is visible after the 68th rising edge since reset.
- R3: The score counts positions where window bit i equals active reference bit i. Window bit 63 is the oldest of the last 64 bits sampled, and window bit 0 is the newest. So a reference sent most significant bit first matches exactly.
- R4: Tolerance code 0 requires a score of 64. Codes 1, 2 and 3 require scores of at least 63, 62 and 61 respectively.
- R5: From the 68th edge onward, exactly one of detect_o and loss_o is high in every cycle. It is detect_o when the score meets the limit and loss_o otherwise.
- R6: The window formed by the edge-n sample is scored, and its result is visible after edge n+4.
- R7: ref_load_i writes ref_i into the staging register at the clock edge. While ref_open_i is high, the active reference equals the staging register in the same cycle. While ref_open_i is low, the active reference keeps its value, and staging writes have no effect on scoring.
- R8: Each window is judged with the tolerance code present during the cycle in which that window is complete. Later code changes do not affect windows already in the pipeline.
- R9: data_o shows the bit sampled at edge n after edge n+73. Before the first bit arrives there, data_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one stream bit per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial data bit |
| ref_i | input | 64 | New reference word for the staging register |
| ref_load_i | input | 1 | Writes ref_i into the staging register |
| ref_open_i | input | 1 | High: active reference follows staging; low: active reference held |
| tol_i | input | 2 | Error-tolerance code, 0 to 3 |
| detect_o | output | 1 | Score met the limit for the current window |
| loss_o | output | 1 | Score missed the limit for the current window |
| data_o | output | 1 | Delayed copy of the stream |

## Verification
The bench aims at the boundary of each tolerance code: 1, 2, 3 and 4 injected errors under codes that sit on either side of the limit. A design with an off-by-one limit would, for example, report loss with three errors under code 3. It writes a new staging word while the holding stage is closed and then streams that new word. A design that leaks staging writes through would detect where loss is expected. It changes the tolerance code every cycle while windows are in flight, and an unregistered code would judge a window with the wrong limit. The first pulse after the pipeline fills and the 73-cycle data delay are timed exactly, so an extra or missing register moves an edge and is caught.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  localparam int unsigned TOL_W = 2;
  typedef logic [TOL_W-1:0] tol_t;

  // side band travelling with each window through the adder pipe
  typedef struct packed {
    logic vld;
    tol_t tol;
  } side_t;
endpackage

// File: rtl/corr_ref_hold.sv
module corr_ref_hold #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ref_i,
  input  logic         load_i,
  input  logic         open_i,
  output logic [W-1:0] ref_act_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] hold_q;

  // transparent stage modelled as flop + bypass mux
  assign ref_act_o = open_i ? stage_q : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      if (load_i) stage_q <= ref_i;
      hold_q <= ref_act_o;
    end
  end
endmodule

// File: rtl/corr_sum_pipe.sv
module corr_sum_pipe #(
  parameter int unsigned W    = 64,
  parameter int unsigned SB_W = 3,
  localparam int unsigned N1   = W / 4,
  localparam int unsigned N2   = W / 16,
  localparam int unsigned NH   = N2 / 2,
  localparam int unsigned C1_W = $clog2(5),
  localparam int unsigned C2_W = $clog2(17),
  localparam int unsigned C3_W = $clog2(W / 2 + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    vec_i,
  input  logic [SB_W-1:0] sb_i,
  output logic [C3_W-1:0] half0_o,
  output logic [C3_W-1:0] half1_o,
  output logic [SB_W-1:0] sb_o
);
  logic [C1_W-1:0] s1_d [N1];
  logic [C1_W-1:0] s1_q [N1];
  logic [C2_W-1:0] s2_d [N2];
  logic [C2_W-1:0] s2_q [N2];
  logic [C3_W-1:0] s3_d [2];
  logic [C3_W-1:0] s3_q [2];
  logic [SB_W-1:0] sb_q [3];

  // stage 1: nibble counts
  for (genvar g = 0; g < N1; g++) begin : g_s1
    assign s1_d[g] = C1_W'(vec_i[4*g]) + C1_W'(vec_i[4*g+1])
                   + C1_W'(vec_i[4*g+2]) + C1_W'(vec_i[4*g+3]);
  end

  // stage 2: sums of four nibble counts
  for (genvar g = 0; g < N2; g++) begin : g_s2
    assign s2_d[g] = C2_W'(s1_q[4*g]) + C2_W'(s1_q[4*g+1])
                   + C2_W'(s1_q[4*g+2]) + C2_W'(s1_q[4*g+3]);
  end

  // stage 3: two half-word sums
  for (genvar h = 0; h < 2; h++) begin : g_s3
    always_comb begin
      s3_d[h] = '0;
      for (int j = 0; j < NH; j++) s3_d[h] = s3_d[h] + C3_W'(s2_q[h*NH+j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N1; i++) s1_q[i] <= '0;
      for (int i = 0; i < N2; i++) s2_q[i] <= '0;
      for (int i = 0; i < 2; i++)  s3_q[i] <= '0;
      for (int i = 0; i < 3; i++)  sb_q[i] <= '0;
    end else begin
      for (int i = 0; i < N1; i++) s1_q[i] <= s1_d[i];
      for (int i = 0; i < N2; i++) s2_q[i] <= s2_d[i];
      for (int i = 0; i < 2; i++)  s3_q[i] <= s3_d[i];
      sb_q[0] <= sb_i;
      sb_q[1] <= sb_q[0];
      sb_q[2] <= sb_q[1];
    end
  end

  assign half0_o = s3_q[0];
  assign half1_o = s3_q[1];
  assign sb_o    = sb_q[2];
endmodule

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (LEN == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_line
    logic [LEN-1:0] line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q <= '0;
      else if (LEN == 1) line_q[0] <= d_i;
      else line_q <= {line_q[LEN-2:0], d_i};
    end
    assign q_o = line_q[LEN-1];
  end
endmodule

// File: rtl/sync_corr.sv
module sync_corr
  import sync_corr_pkg::*;
#(
  parameter int unsigned W         = 64,
  parameter int unsigned DELAY_LEN = 10,
  localparam int unsigned SC_W     = $clog2(W + 1),
  localparam int unsigned C3_W     = $clog2(W / 2 + 1),
  localparam int unsigned SB_W     = $bits(side_t)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic [W-1:0] ref_i,
  input  logic         ref_load_i,
  input  logic         ref_open_i,
  input  logic [1:0]   tol_i,
  output logic         detect_o,
  output logic         loss_o,
  output logic         data_o
);
  logic [W-1:0]    win_q;
  logic [SC_W-1:0] fill_q;
  logic [W-1:0]    ref_act;
  logic [W-1:0]    agree;
  side_t           sb_in, sb_out;
  logic [C3_W-1:0] half0, half1;
  logic [SC_W-1:0] score, limit;
  logic            det_q, loss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q <= {win_q[W-2:0], bit_i};
      if (fill_q != SC_W'(W)) fill_q <= fill_q + SC_W'(1);
    end
  end

  corr_ref_hold #(.W(W)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ref_i),
    .load_i   (ref_load_i),
    .open_i   (ref_open_i),
    .ref_act_o(ref_act)
  );

  assign agree     = ~(win_q ^ ref_act);
  assign sb_in.vld = (fill_q == SC_W'(W));
  assign sb_in.tol = tol_i;

  corr_sum_pipe #(.W(W), .SB_W(SB_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (agree),
    .sb_i   (sb_in),
    .half0_o(half0),
    .half1_o(half1),
    .sb_o   (sb_out)
  );

  // stage 4: final add and limit test
  assign score = SC_W'(half0) + SC_W'(half1);
  assign limit = SC_W'(W) - SC_W'(sb_out.tol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q  <= 1'b0;
      loss_q <= 1'b0;
    end else begin
      det_q  <= sb_out.vld && (score >= limit);
      loss_q <= sb_out.vld && (score < limit);
    end
  end

  assign detect_o = det_q;
  assign loss_o   = loss_q;

  corr_delay #(.LEN(DELAY_LEN)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (win_q[W-1]),
    .q_o   (data_o)
  );
endmodule

// File: rtl/sync_corr_chk.sv
module sync_corr_chk #(
  parameter int unsigned W = 64,
  localparam int unsigned FILL = W + 4,
  localparam int unsigned CY_W = $clog2(FILL + 1)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ref_open_i,
  input logic         ref_load_i,
  input logic [W-1:0] ref_i,
  input logic [W-1:0] ref_act_i,
  input logic         detect_o,
  input logic         loss_o
);
  logic [CY_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != CY_W'(FILL)) cyc_q <= cyc_q + CY_W'(1);
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(detect_o && loss_o)); // R5

  AST_QUIET_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < CY_W'(FILL)) |-> (!detect_o && !loss_o)); // R2

  AST_PULSE_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CY_W'(FILL)) |-> (detect_o || loss_o)); // R5

  AST_REF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_open_i && $past(!ref_open_i)) |-> $stable(ref_act_i)); // R7

  AST_REF_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_open_i && $past(ref_open_i && ref_load_i)) |-> (ref_act_i == $past(ref_i))); // R7
endmodule

bind sync_corr sync_corr_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_open_i(ref_open_i),
  .ref_load_i(ref_load_i),
  .ref_i     (ref_i),
  .ref_act_i (ref_act),
  .detect_o  (detect_o),
  .loss_o    (loss_o)
);

// File: tb/tb_sync_corr.sv
`timescale 1ns/1ps
module tb_sync_corr;
  localparam int W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bit_in = 1'b0;
  logic [W-1:0] ref_in = '0;
  logic         ref_load = 1'b0;
  logic         ref_open = 1'b1;
  logic [1:0]   tol_in = 2'd0;
  logic         detect_o, loss_o, data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R2";

  always #4 clk_i = ~clk_i;

  sync_corr dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (bit_in),
    .ref_i     (ref_in),
    .ref_load_i(ref_load),
    .ref_open_i(ref_open),
    .tol_i     (tol_in),
    .detect_o  (detect_o),
    .loss_o    (loss_o),
    .data_o    (data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge check)", req, act, exp);
    end
  endtask

  // behavioural reference model, evaluated at every rising edge
  int          n = 0;
  int          fill_m = 0;
  logic [W-1:0] win_m = '0, stag_m = '0, hold_m = '0, act_m;
  int          score_m;
  bit          qd[$], ql[$], qb[$];

  always @(posedge clk_i) begin
    if (rst_ni) begin
      act_m = ref_open ? stag_m : hold_m;
      score_m = 0;
      for (int i = 0; i < W; i++) if (win_m[i] == act_m[i]) score_m++;
      qd.push_back(fill_m == W && score_m >= W - int'(tol_in));
      ql.push_back(fill_m == W && score_m <  W - int'(tol_in));
      qb.push_back(bit_in);
      win_m = {win_m[W-2:0], bit_in};
      if (fill_m < W) fill_m++;
      if (ref_load) stag_m = ref_in;
      hold_m = act_m;
      n++;
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk_i) begin
    if (rst_ni && n > 0 && !done) begin
      bit ed, el, eb;
      ed = (n >= 4) ? qd[n-4] : 1'b0;
      el = (n >= 4) ? ql[n-4] : 1'b0;
      eb = (n >= 74) ? qb[n-74] : 1'b0;
      check(detect_o == ed, {cur_req, " detect"}, detect_o, ed);
      check(loss_o == el, {cur_req, " loss"}, loss_o, el);
      check(data_o == eb, "R9 data", data_o, eb);
    end
  end

  task automatic step(input logic b, input logic ld = 1'b0, input logic [W-1:0] val = '0);
    @(negedge clk_i);
    bit_in = b;
    ref_load = ld;
    if (ld) ref_in = val;
  endtask

  task automatic send(input logic [W-1:0] pat, input logic [W-1:0] flips);
    for (int i = W - 1; i >= 0; i--) step(pat[i] ^ flips[i]);
  endtask

  task automatic noise(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'($urandom));
  endtask

  localparam logic [W-1:0] P1 = 64'h0c28_f22c_ed7d_0e24;
  localparam logic [W-1:0] P2 = 64'h5a93_e10f_3c66_b7d8;

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(detect_o == 1'b0, "R1 detect", detect_o, 0);
    check(loss_o == 1'b0, "R1 loss", loss_o, 0);
    check(data_o == 1'b0, "R1 data", data_o, 0);
    rst_ni = 1'b1;

    // R2: fill phase, staging loaded with latch open
    cur_req = "R2";
    step(1'b1, 1'b1, P1);
    noise(70);

    // R3 R6: exact match, result four edges after the last bit
    cur_req = "R3/R6";
    send(P1, '0);
    noise(6);

    // R4: limits around each tolerance code
    cur_req = "R4";
    tol_in = 2'd0; send(P1, 64'h1);
    tol_in = 2'd1; send(P1, 64'h8000_0000_0000_0000);
    tol_in = 2'd1; send(P1, 64'h0000_0100_0000_0001);
    tol_in = 2'd2; send(P1, 64'h0000_0100_0000_0001);
    tol_in = 2'd2; send(P1, 64'h0010_0100_0000_0001);
    tol_in = 2'd3; send(P1, 64'h0010_0100_0000_0001);
    tol_in = 2'd3; send(P1, 64'h0010_0100_8000_0001);
    noise(5);

    // R7: staging write while held has no effect on scoring
    cur_req = "R7";
    tol_in = 2'd0;
    ref_open = 1'b0;
    step(1'b0, 1'b1, P2);
    send(P2, '0);
    send(P1, '0);
    ref_open = 1'b1;
    send(P2, '0);
    noise(5);

    // R8: code changing every cycle while windows are in flight
    cur_req = "R8";
    for (int k = 0; k < 3; k++) begin
      for (int i = W - 1; i >= 0; i--) begin
        tol_in = 2'(i + k);
        step(P2[i] ^ (i == 5 || i == 40));
      end
    end

    // R5: every post-fill cycle carries exactly one pulse
    cur_req = "R5";
    noise(120);
    repeat (6) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule